// File: doc/BRIEF.md
# Floating-point multiply-accumulate instruction decoder

This block takes one 32-bit instruction word and checks whether it encodes a floating-point multiply-accumulate, where the product is added to the destination, or a multiply-subtract, where the product is negated before it is added. It recognises four encodings: a vector form and a scalar form for each of two instruction sets. One set has only 32-bit words. The other mixes 16-bit and 32-bit words.

For a word that matches, the block reports the operation kind and the shape of the data. The shape is the element width, the number of elements in a 64-bit register and the number of registers. It also reports the three 5-bit register numbers, rebuilt from their split fields in the bit order that the precision calls for. The undefined and unpredictable rules depend on four things: the precision, the half-precision support strap, the conditional-block flag, and the vector length and stride settings. Both verdicts are flagged. A pipeline stage feeds in one word with a valid strobe, and the decoded result appears one cycle later.

Top module: `fmac_insn_decode`

## Requirements
- R1: Reset clears every output to 0. `out_valid` equals `in_valid` delayed by one cycle. All other outputs are registered and change only in the cycle after a word is presented with `in_valid`=1, and they hold their value otherwise.
- R2: With `mixed_set`=0, a word is a vector match when bits 31:23 = 111100100, bits 11:8 = 1101 and bit 4 = 1. With `mixed_set`=1, the same rule applies except that bits 31:24 must be 11101111 (bit 23 still 0). In both vector forms the fields are D=22, op=21, sz=20, Vn=19:16, Vd=15:12, N=7, Q=6, M=5 and Vm=3:0. A vector match gives `hit`=1 and `is_vector`=1.
- R3: A word is a scalar match when bits 27:23 = 11100, bits 21:20 = 00, bits 11:10 = 10 and bit 4 = 0. In addition, bits 31:28 must not be 1111 when `mixed_set`=0, and must equal 1110 when `mixed_set`=1. In the scalar forms, size sits at bits 9:8 and op at bit 6. The other fields are in the vector positions. A scalar match gives `hit`=1 and `is_vector`=0.
- R4: A word that matches neither form gives `hit`=0. Every other decoded output is then 0, and only `out_valid` follows R1.
- R5: `subtract` equals the op bit: bit 21 in the vector forms, bit 6 in the scalar forms.
- R6: In the vector forms, `elem_bits` is 32 when sz=0 and 16 when sz=1, and `elem_count` is 64 divided by `elem_bits`. `reg_count` is 1 when Q=0 and 2 when Q=1.
- R7: Vector register numbers are {D,Vd}, {N,Vn} and {M,Vm}. A vector word with Q=1 and bit 0 of Vd, Vn or Vm set is undefined.
- R8: The following are undefined: vector sz=1 while `half_ok`=0, scalar size=00, and scalar size=01 while `half_ok`=0.
- R9: A scalar word is undefined when `vec_len` is not 000 or `vec_stride` is not 00. Vector words ignore both inputs.
- R10: In the scalar forms, `elem_bits` = 8 << size, and `elem_count` and `reg_count` are 0. The register numbers are {Vd,D}, {Vn,N} and {Vm,M} when size is 01 or 10, and {D,Vd}, {N,Vn} and {M,Vm} when size is 11.
- R11: A word is unpredictable in three cases: a 32-bit-only scalar half-precision word (size=01) with condition other than 1110; a mixed-set scalar half-precision word while `in_cond_blk`=1; a mixed-set vector word with sz=1 while `in_cond_blk`=1. An undefined word is never also reported unpredictable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Word on `insn` is presented this cycle |
| insn | input | 32 | Instruction word |
| mixed_set | input | 1 | 1: mixed 16/32-bit set, 0: 32-bit-only set |
| in_cond_blk | input | 1 | Word sits inside a conditional block |
| half_ok | input | 1 | Half-precision arithmetic is supported |
| vec_len | input | 3 | Vector length field of the FP control register |
| vec_stride | input | 2 | Vector stride field of the FP control register |
| out_valid | output | 1 | Decoded result valid |
| hit | output | 1 | Word is one of the four encodings |
| undef | output | 1 | Matched word is undefined |
| unpred | output | 1 | Matched word is unpredictable |
| subtract | output | 1 | Product is negated before the add |
| is_vector | output | 1 | Vector form |
| elem_bits | output | 7 | Element width in bits |
| elem_count | output | 3 | Elements per 64-bit register (vector only) |
| reg_count | output | 2 | Registers processed (vector only) |
| rd | output | 5 | Destination register number |
| rn | output | 5 | First source register number |
| rm | output | 5 | Second source register number |

## Verification
The undefined and unpredictable verdicts can both be triggered by the same word. The bench forces this in two ways. It presents a half-precision scalar word with a non-1110 condition while `vec_len` is nonzero, so the length rule and the condition rule both apply. It also presents a mixed-set half vector inside a conditional block with the strap cleared. In each case it expects `undef`=1 and `unpred`=0. Separate words then clear one cause at a time, to show that each verdict still appears on its own.

// File: rtl/fmac_insn_decode.sv
module fmac_insn_decode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] insn,
  input  logic        mixed_set,
  input  logic        in_cond_blk,
  input  logic        half_ok,
  input  logic [2:0]  vec_len,
  input  logic [1:0]  vec_stride,
  output logic        out_valid,
  output logic        hit,
  output logic        undef,
  output logic        unpred,
  output logic        subtract,
  output logic        is_vector,
  output logic [6:0]  elem_bits,
  output logic [2:0]  elem_count,
  output logic [1:0]  reg_count,
  output logic [4:0]  rd,
  output logic [4:0]  rn,
  output logic [4:0]  rm
);

  wire [3:0] cond  = insn[31:28];
  wire       f_d   = insn[22];
  wire       f_n   = insn[7];
  wire       f_m   = insn[5];
  wire [3:0] f_vn  = insn[19:16];
  wire [3:0] f_vd  = insn[15:12];
  wire [3:0] f_vm  = insn[3:0];
  wire       f_sz  = insn[20];
  wire       f_q   = insn[6];
  wire [1:0] f_size = insn[9:8];

  wire vec_body = !insn[23] && insn[11:8] == 4'b1101 && insn[4];
  wire vec_top  = mixed_set ? (insn[31:24] == 8'b1110_1111) : (insn[31:24] == 8'b1111_0010);
  wire vec_hit  = vec_body && vec_top;

  wire sc_body  = insn[27:23] == 5'b11100 && insn[21:20] == 2'b00 &&
                  insn[11:10] == 2'b10 && !insn[4];
  wire sc_cond  = mixed_set ? (cond == 4'b1110) : (cond != 4'b1111);
  wire sc_hit   = sc_body && sc_cond;

  wire sc_half  = f_size == 2'b01;
  wire sc_wide  = f_size == 2'b11;

  wire vec_undef = (f_q && (f_vd[0] || f_vn[0] || f_vm[0])) || (f_sz && !half_ok);
  wire vec_unp   = mixed_set && f_sz && in_cond_blk;
  wire sc_undef  = f_size == 2'b00 || (sc_half && !half_ok) ||
                   vec_len != 3'd0 || vec_stride != 2'd0;
  wire sc_unp    = sc_half && (mixed_set ? in_cond_blk : (cond != 4'b1110));

  logic       n_hit, n_undef, n_unpred, n_sub, n_vec;
  logic [6:0] n_ebits;
  logic [2:0] n_ecnt;
  logic [1:0] n_rcnt;
  logic [4:0] n_rd, n_rn, n_rm;

  always_comb begin
    n_hit = 1'b0; n_undef = 1'b0; n_unpred = 1'b0; n_sub = 1'b0; n_vec = 1'b0;
    n_ebits = '0; n_ecnt = '0; n_rcnt = '0; n_rd = '0; n_rn = '0; n_rm = '0;
    if (vec_hit) begin
      n_hit    = 1'b1;
      n_vec    = 1'b1;
      n_sub    = insn[21];
      n_undef  = vec_undef;
      n_unpred = vec_unp && !vec_undef;
      n_ebits  = f_sz ? 7'd16 : 7'd32;
      n_ecnt   = f_sz ? 3'd4 : 3'd2;
      n_rcnt   = f_q ? 2'd2 : 2'd1;
      n_rd     = {f_d, f_vd};
      n_rn     = {f_n, f_vn};
      n_rm     = {f_m, f_vm};
    end else if (sc_hit) begin
      n_hit    = 1'b1;
      n_sub    = insn[6];
      n_undef  = sc_undef;
      n_unpred = sc_unp && !sc_undef;
      n_ebits  = 7'd8 << f_size;
      n_rd     = sc_wide ? {f_d, f_vd} : {f_vd, f_d};
      n_rn     = sc_wide ? {f_n, f_vn} : {f_vn, f_n};
      n_rm     = sc_wide ? {f_m, f_vm} : {f_vm, f_m};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      hit <= 1'b0; undef <= 1'b0; unpred <= 1'b0; subtract <= 1'b0; is_vector <= 1'b0;
      elem_bits <= '0; elem_count <= '0; reg_count <= '0;
      rd <= '0; rn <= '0; rm <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        hit <= n_hit; undef <= n_undef; unpred <= n_unpred;
        subtract <= n_sub; is_vector <= n_vec;
        elem_bits <= n_ebits; elem_count <= n_ecnt; reg_count <= n_rcnt;
        rd <= n_rd; rn <= n_rn; rm <= n_rm;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({hit, undef, unpred, subtract, is_vector, elem_bits, rd, rn, rm})); // R1
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !undef && !unpred && !is_vector && elem_bits == 7'd0 && rd == 5'd0 && rn == 5'd0 && rm == 5'd0); // R4
  AST_VEC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    hit && is_vector |-> (elem_bits == 7'd32 && elem_count == 3'd2) ||
                         (elem_bits == 7'd16 && elem_count == 3'd4)); // R6
  AST_QUAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    hit && is_vector && reg_count == 2'd2 && (rd[0] || rn[0] || rm[0]) |-> undef); // R7
  AST_SCALAR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !is_vector |-> elem_count == 3'd0 && reg_count == 2'd0); // R10
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef && unpred)); // R11

endmodule

// File: tb/test_fmac_insn_decode.sv
module test_fmac_insn_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic mixed_set = 1'b0, in_cond_blk = 1'b0, half_ok = 1'b1;
  logic [2:0] vec_len = '0;
  logic [1:0] vec_stride = '0;
  logic out_valid, hit, undef, unpred, subtract, is_vector;
  logic [6:0] elem_bits;
  logic [2:0] elem_count;
  logic [1:0] reg_count;
  logic [4:0] rd, rn, rm;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fmac_insn_decode i_fmac_insn_decode (.*);

  function automatic logic [31:0] vword(input logic mx, d, op, sz, input logic [3:0] vn, vd,
                                        input logic n, q, m, input logic [3:0] vm);
    return {(mx ? 8'hEF : 8'hF2), 1'b0, d, op, sz, vn, vd, 4'hD, n, q, m, 1'b1, vm};
  endfunction

  function automatic logic [31:0] sword(input logic [3:0] c, input logic d, input logic [3:0] vn, vd,
                                        input logic [1:0] sz, input logic n, op, m, input logic [3:0] vm);
    return {c, 5'b11100, d, 2'b00, vn, vd, 2'b10, sz, n, op, m, 1'b0, vm};
  endfunction

  function automatic logic [32:0] pack(input logic v, h, u, p, s, ve, input logic [6:0] eb,
                                       input logic [2:0] ec, input logic [1:0] rc,
                                       input logic [4:0] a, b, c);
    return {v, h, u, p, s, ve, eb, ec, rc, a, b, c};
  endfunction

  task automatic check(input string req, input logic [32:0] exp);
    logic [32:0] act;
    act = pack(out_valid, hit, undef, unpred, subtract, is_vector, elem_bits, elem_count,
               reg_count, rd, rn, rm);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic mx, itb, hk,
                       input logic [2:0] ln, input logic [1:0] st);
    @(negedge clk);
    insn = w; mixed_set = mx; in_cond_blk = itb; half_ok = hk; vec_len = ln; vec_stride = st;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", '0);
  endtask

  task automatic t_vec_fixed();
    apply(vword(0, 1, 0, 0, 4'd5, 4'd3, 0, 0, 1, 4'd10), 0, 0, 1, 3'd0, 2'd0);
    check("R2 R6 R7 fixed vector", pack(1, 1, 0, 0, 0, 1, 32, 2, 1, 19, 5, 26));
    apply(vword(0, 0, 0, 0, 4'd1, 4'd2, 0, 0, 0, 4'd3), 0, 0, 1, 3'd5, 2'd3);
    check("R9 vector ignores len/stride", pack(1, 1, 0, 0, 0, 1, 32, 2, 1, 2, 1, 3));
  endtask

  task automatic t_vec_mixed_quad();
    apply(vword(1, 0, 1, 0, 4'd8, 4'd4, 1, 1, 0, 4'd2), 1, 0, 1, 3'd0, 2'd0);
    check("R2 R5 R6 mixed quad", pack(1, 1, 0, 0, 1, 1, 32, 2, 2, 4, 24, 2));
    apply(vword(1, 0, 0, 0, 4'd3, 4'd4, 0, 1, 0, 4'd2), 1, 0, 1, 3'd0, 2'd0);
    check("R7 odd quad register", pack(1, 1, 1, 0, 0, 1, 32, 2, 2, 4, 3, 2));
  endtask

  task automatic t_vec_half();
    apply(vword(0, 0, 0, 1, 4'd0, 4'd6, 0, 0, 0, 4'd7), 0, 0, 1, 3'd0, 2'd0);
    check("R6 half vector", pack(1, 1, 0, 0, 0, 1, 16, 4, 1, 6, 0, 7));
    apply(vword(0, 0, 0, 1, 4'd0, 4'd6, 0, 0, 0, 4'd7), 0, 0, 0, 3'd0, 2'd0);
    check("R8 half vector no support", pack(1, 1, 1, 0, 0, 1, 16, 4, 1, 6, 0, 7));
    apply(vword(1, 0, 0, 1, 4'd0, 4'd6, 0, 0, 0, 4'd7), 1, 1, 1, 3'd0, 2'd0);
    check("R11 half vector in block", pack(1, 1, 0, 1, 0, 1, 16, 4, 1, 6, 0, 7));
    apply(vword(1, 0, 0, 1, 4'd0, 4'd6, 0, 0, 0, 4'd7), 1, 1, 0, 3'd0, 2'd0);
    check("R11 undef dominates vector", pack(1, 1, 1, 0, 0, 1, 16, 4, 1, 6, 0, 7));
  endtask

  task automatic t_scalar();
    apply(sword(4'h0, 1, 4'd5, 4'd3, 2'b10, 0, 1, 1, 4'd15), 0, 0, 1, 3'd0, 2'd0);
    check("R3 R5 R10 single scalar", pack(1, 1, 0, 0, 1, 0, 32, 0, 0, 7, 10, 31));
    apply(sword(4'hE, 1, 4'd5, 4'd3, 2'b11, 1, 0, 0, 4'd9), 1, 0, 1, 3'd0, 2'd0);
    check("R3 R10 double scalar mixed", pack(1, 1, 0, 0, 0, 0, 64, 0, 0, 19, 21, 9));
    apply(sword(4'h0, 0, 4'd1, 4'd2, 2'b00, 0, 0, 0, 4'd3), 0, 0, 1, 3'd0, 2'd0);
    check("R8 size 00", pack(1, 1, 1, 0, 0, 0, 8, 0, 0, 4, 2, 6));
    apply(sword(4'hE, 0, 4'd1, 4'd2, 2'b01, 0, 0, 0, 4'd3), 0, 0, 0, 3'd0, 2'd0);
    check("R8 half scalar no support", pack(1, 1, 1, 0, 0, 0, 16, 0, 0, 4, 2, 6));
  endtask

  task automatic t_len_stride();
    apply(sword(4'hE, 0, 4'd1, 4'd2, 2'b10, 0, 0, 0, 4'd3), 0, 0, 1, 3'd1, 2'd0);
    check("R9 length", pack(1, 1, 1, 0, 0, 0, 32, 0, 0, 4, 2, 6));
    apply(sword(4'hE, 0, 4'd1, 4'd2, 2'b10, 0, 0, 0, 4'd3), 0, 0, 1, 3'd0, 2'd2);
    check("R9 stride", pack(1, 1, 1, 0, 0, 0, 32, 0, 0, 4, 2, 6));
  endtask

  task automatic t_unpred();
    apply(sword(4'h1, 0, 4'd1, 4'd2, 2'b01, 0, 0, 0, 4'd3), 0, 0, 1, 3'd0, 2'd0);
    check("R11 half cond", pack(1, 1, 0, 1, 0, 0, 16, 0, 0, 4, 2, 6));
    apply(sword(4'hE, 0, 4'd1, 4'd2, 2'b01, 0, 0, 0, 4'd3), 0, 1, 1, 3'd0, 2'd0);
    check("R11 half always", pack(1, 1, 0, 0, 0, 0, 16, 0, 0, 4, 2, 6));
    apply(sword(4'hE, 0, 4'd1, 4'd2, 2'b01, 0, 0, 0, 4'd3), 1, 1, 1, 3'd0, 2'd0);
    check("R11 half in block", pack(1, 1, 0, 1, 0, 0, 16, 0, 0, 4, 2, 6));
    apply(sword(4'h1, 0, 4'd1, 4'd2, 2'b01, 0, 0, 0, 4'd3), 0, 0, 1, 3'd2, 2'd0);
    check("R11 undef dominates scalar", pack(1, 1, 1, 0, 0, 0, 16, 0, 0, 4, 2, 6));
  endtask

  task automatic t_miss();
    apply(sword(4'hF, 0, 4'd1, 4'd2, 2'b10, 0, 0, 0, 4'd3), 0, 0, 1, 3'd0, 2'd0);
    check("R4 cond 1111", pack(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    apply(sword(4'h0, 0, 4'd1, 4'd2, 2'b10, 0, 0, 0, 4'd3), 1, 0, 1, 3'd0, 2'd0);
    check("R4 mixed needs 1110", pack(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    apply(vword(0, 1, 1, 0, 4'd5, 4'd3, 0, 0, 1, 4'd10), 1, 0, 1, 3'd0, 2'd0);
    check("R4 wrong set vector", pack(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    apply(vword(0, 1, 1, 0, 4'd5, 4'd3, 0, 0, 1, 4'd10) & ~32'h10, 0, 0, 1, 3'd0, 2'd0);
    check("R4 bit4 clear", pack(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_hold();
    apply(vword(0, 1, 0, 0, 4'd5, 4'd3, 0, 0, 1, 4'd10), 0, 0, 1, 3'd0, 2'd0);
    @(negedge clk);
    insn = sword(4'h0, 0, 4'd1, 4'd2, 2'b11, 0, 1, 0, 4'd3);
    @(negedge clk);
    check("R1 hold when idle", pack(0, 1, 0, 0, 0, 1, 32, 2, 1, 19, 5, 26));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_vec_fixed();
    t_vec_mixed_quad();
    t_vec_half();
    t_scalar();
    t_len_stride();
    t_unpred();
    t_miss();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule